// File: doc/BRIEF.md
# Multi-Lane Byte Deskew and Word Bonding

This block rebuilds 32-bit words that were sent one byte per lane over four receive lanes. Each lane can arrive with its own delay, so taking one byte from each lane on the same cycle can mix bytes from different words. Every lane writes into its own small FIFO. All lanes are read under one shared clock.

While searching, the block watches each lane's write side for a bonding marker character. It records where the first marker of every lane was stored. Once all four lanes have shown a marker inside the skew window, each lane's read pointer is moved to its own marker entry. Output then starts with a word made entirely of markers, and every later word is reassembled correctly. If the window closes with a lane still missing, the block flags an alignment error and starts the search again. If a later output word carries the marker on some lanes but not all, the block drops its bonded state and searches again.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `word_vld_o`, `bonded_o` and `align_err_o` are all low.
- R2: An output word holds one byte per lane: lane k sits in bits [8k+7:8k], so lane 0 is the least significant byte.
- R3: While searching, the first marker written on each lane is recorded. When the last missing lane presents its marker in cycle t, an all-marker word appears on the outputs in cycle t+2, after two rising edges.
- R4: A lane's marker is accepted if it arrives up to SKEW (default 4) cycles after the first recorded marker. Arriving exactly SKEW cycles later still bonds.
- R5: If cycle f+SKEW passes, where f is the cycle of the first recorded marker, and some lane still has no marker, `align_err_o` pulses high for exactly one cycle. All recorded markers are discarded and the search restarts. `bonded_o` is never high together with `align_err_o`.
- R6: `bonded_o` rises on the same cycle as the first all-marker word.
- R7: Once bonded, one word is output per cycle in which every lane holds unread data. No word is output while any lane is empty.
- R8: When bonded and a word is read whose bytes equal the marker on some lanes but not all, that word is still output. `bonded_o` falls on that same cycle and the block returns to searching.
- R9: While searching, `word_vld_o` stays low, apart from the single word output on the cycle bonding is lost.
- R10: An output word with the marker on all four lanes keeps `bonded_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common write and read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | 32 | Incoming byte of each lane, lane k at bits [8k+7:8k] |
| lane_vld_i | input | 4 | Per-lane byte valid |
| marker_i | input | 8 | Bonding marker value, held stable during operation |
| word_o | output | 32 | Reassembled word |
| word_vld_o | output | 1 | Word valid |
| bonded_o | output | 1 | Lanes aligned |
| align_err_o | output | 1 | One-cycle pulse when the skew window expires |

## Verification
A byte written in cycle t can reach `word_o` no earlier than cycle t+2: one edge stores it, one edge registers the read. The first all-marker word therefore follows the last marker by exactly two cycles. `align_err_o` is registered off the window counter, so it appears one cycle after the expiring cycle f+SKEW. The reference model advances one step per rising edge using the inputs the design sampled at that edge. Outputs are compared at the next falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_BOND   = 1'b1
  } bond_st_e;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] marker_i,
  input  logic         cap_i,
  input  logic         load_i,
  input  logic         rd_en_i,
  output logic         mark_o,
  output logic         nonempty_o,
  output logic [W-1:0] rd_data_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, mpos_q;

  assign mark_o     = wr_en_i && (wr_data_i == marker_i);
  assign nonempty_o = (wr_ptr_q != rd_ptr_q);
  assign rd_data_o  = mem_q[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      mpos_q   <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (cap_i)   mpos_q   <= wr_ptr_q;
      // a marker captured this cycle lands at the current write slot
      if (load_i)       rd_ptr_q <= cap_i ? wr_ptr_q : mpos_q;
      else if (rd_en_i) rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  // R3
  load_lands_on_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rd_data_o == $past(marker_i)));
endmodule

// File: rtl/deskew_bond_ctrl.sv
module deskew_bond_ctrl
  import lane_deskew_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SKEW  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] mark_i,
  input  logic             lost_i,
  output logic [LANES-1:0] cap_o,
  output logic             load_o,
  output logic             bond_o,
  output logic             err_o
);
  localparam int CW = $clog2(SKEW + 1);

  bond_st_e         st_q;
  logic [LANES-1:0] seen_q;
  logic [CW-1:0]    cnt_q;
  logic             srch, all_raw, err_now;

  assign srch    = (st_q == ST_SEARCH);
  assign all_raw = srch && (&(seen_q | mark_i));
  assign err_now = srch && (|seen_q) && !all_raw && (cnt_q == CW'(SKEW - 1));
  assign cap_o   = (srch && !err_now) ? (mark_i & ~seen_q) : '0;
  assign load_o  = all_raw;
  assign bond_o  = (st_q == ST_BOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      seen_q <= '0;
      cnt_q  <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= err_now;
      if (err_now || all_raw) begin
        seen_q <= '0;
        cnt_q  <= '0;
      end else begin
        seen_q <= seen_q | cap_o;
        cnt_q  <= (seen_q == '0) ? '0 : cnt_q + CW'(1);
      end
      if (all_raw)               st_q <= ST_BOND;
      else if (bond_o && lost_i) st_q <= ST_SEARCH;
    end
  end

  // R4
  window_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(SKEW));
  // R5
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R5
  err_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (seen_q == '0));
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int SKEW  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES*W-1:0] lane_data_i,
  input  logic [LANES-1:0]   lane_vld_i,
  input  logic [W-1:0]       marker_i,
  output logic [LANES*W-1:0] word_o,
  output logic               word_vld_o,
  output logic               bonded_o,
  output logic               align_err_o
);
  logic [LANES-1:0] mark, cap, nonempty, rd_is_mark;
  logic [W-1:0]     rd_byte [LANES];
  logic [LANES*W-1:0] rd_word;
  logic load, bond_st, rd_en, partial;

  deskew_bond_ctrl #(.LANES(LANES), .SKEW(SKEW)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (mark),
    .lost_i (rd_en && partial),
    .cap_o  (cap),
    .load_o (load),
    .bond_o (bond_st),
    .err_o  (align_err_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    deskew_lane_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (lane_vld_i[k]),
      .wr_data_i  (lane_data_i[k*W +: W]),
      .marker_i   (marker_i),
      .cap_i      (cap[k]),
      .load_i     (load),
      .rd_en_i    (rd_en),
      .mark_o     (mark[k]),
      .nonempty_o (nonempty[k]),
      .rd_data_o  (rd_byte[k])
    );
    assign rd_is_mark[k]         = (rd_byte[k] == marker_i);
    assign rd_word[k*W +: W]     = rd_byte[k];
  end

  assign rd_en   = bond_st && (&nonempty);
  assign partial = (|rd_is_mark) && !(&rd_is_mark);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
      bonded_o   <= 1'b0;
    end else begin
      word_vld_o <= rd_en;
      if (rd_en) begin
        word_o   <= rd_word;
        bonded_o <= !partial;
      end
    end
  end

  // R9
  quiet_search_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bond_st |=> !word_vld_o);
  // R6
  bond_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bonded_o) |-> (word_vld_o && word_o == {LANES{marker_i}}));
  // R8
  drop_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bonded_o) |-> word_vld_o);
  // R5
  err_not_bonded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !bonded_o);
endmodule

// File: tb/lane_deskew_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_tb_top;
  localparam int LANES = 4;
  localparam int W     = 8;
  localparam int SKEW  = 4;
  localparam logic [7:0] MARK = 8'hBC;

  logic clk, rst_n;
  logic [31:0] lane_data;
  logic [3:0]  lane_vld;
  logic [31:0] word;
  logic word_vld, bonded, align_err;

  lane_deskew dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lane_data_i(lane_data), .lane_vld_i(lane_vld),
    .marker_i(MARK), .word_o(word), .word_vld_o(word_vld), .bonded_o(bonded),
    .align_err_o(align_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL R7 watchdog expired act=%0d exp=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] hist [4][$];
  int rdp [4], mpos [4];
  bit seen [4];
  int cnt, st;
  bit exp_v, exp_b, exp_e;
  logic [31:0] exp_d;

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      hist[k].delete(); rdp[k] = 0; mpos[k] = 0; seen[k] = 0;
    end
    cnt = 0; st = 0; exp_v = 0; exp_b = 0; exp_e = 0; exp_d = '0;
  endtask

  task automatic model_step(input logic [3:0] v, input logic [31:0] d);
    bit rd, all_raw, err, any_seen;
    bit mk [4];
    int nm, st_n;
    st_n = st;
    rd = (st == 1);
    for (int k = 0; k < 4; k++) if (hist[k].size() <= rdp[k]) rd = 0;
    exp_v = rd;
    if (rd) begin
      nm = 0;
      for (int k = 0; k < 4; k++) begin
        exp_d[k*8 +: 8] = hist[k][rdp[k]];
        if (hist[k][rdp[k]] == MARK) nm++;
        rdp[k]++;
      end
      exp_b = !(nm > 0 && nm < 4);
      if (!exp_b) st_n = 0;
    end
    err = 0;
    if (st == 0) begin
      all_raw = 1; any_seen = 0;
      for (int k = 0; k < 4; k++) begin
        mk[k] = v[k] && d[k*8 +: 8] == MARK;
        if (!(seen[k] || mk[k])) all_raw = 0;
        if (seen[k]) any_seen = 1;
      end
      err = any_seen && !all_raw && cnt == SKEW - 1;
      if (all_raw) begin
        for (int k = 0; k < 4; k++) begin
          rdp[k] = seen[k] ? mpos[k] : hist[k].size();
          seen[k] = 0;
        end
        cnt = 0; st_n = 1;
      end else if (err) begin
        for (int k = 0; k < 4; k++) seen[k] = 0;
        cnt = 0;
      end else begin
        cnt = any_seen ? cnt + 1 : 0;
        for (int k = 0; k < 4; k++)
          if (mk[k] && !seen[k]) begin seen[k] = 1; mpos[k] = hist[k].size(); end
      end
    end
    exp_e = err;
    for (int k = 0; k < 4; k++) if (v[k]) hist[k].push_back(d[k*8 +: 8]);
    st = st_n;
  endtask

  function automatic logic [7:0] gen(int n, int k);
    return (n % 16 == 0) ? MARK : 8'((n * 4 + k) % 128);
  endfunction

  int n_bond, n_err, n_fall;
  logic [31:0] first_word;
  bit got_first, prev_b;

  task automatic run(input int d0, d1, d2, d3, input int nwords, input bit gap,
                     input int slip_lane, input int slip_at);
    int dl [4];
    int tick, idx;
    dl[0] = d0; dl[1] = d1; dl[2] = d2; dl[3] = d3;
    n_bond = 0; n_err = 0; n_fall = 0; got_first = 0; prev_b = 0; first_word = '0;
    rst_n = 1'b0; lane_vld = '0; lane_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(word_vld == 0 && bonded == 0 && align_err == 0, "R1 reset outputs",
        {29'd0, word_vld, bonded, align_err}, 32'd0);
    rst_n = 1'b1;
    tick = 0;
    for (int c = 0; c < nwords + 40; c++) begin
      if (c > 0) begin
        @(negedge clk);
        model_step(lane_vld, lane_data);
        chk(word_vld == exp_v, "R7 R9 word valid", {31'd0, word_vld}, {31'd0, exp_v});
        chk(word == exp_d, "R2 word content", word, exp_d);
        chk(bonded == exp_b, "R6 R8 R10 bonded flag", {31'd0, bonded}, {31'd0, exp_b});
        chk(align_err == exp_e, "R4 R5 alignment error", {31'd0, align_err}, {31'd0, exp_e});
        if (bonded) n_bond++;
        if (align_err) n_err++;
        if (prev_b && !bonded) n_fall++;
        if (word_vld && !got_first) begin got_first = 1; first_word = word; end
        prev_b = bonded;
      end
      lane_vld = '0;
      if (!(gap && c % 7 == 6)) begin
        for (int k = 0; k < 4; k++) begin
          idx = tick - dl[k];
          if (k == slip_lane && idx >= slip_at) idx--;
          if (idx >= 0 && idx < nwords) begin
            lane_vld[k] = 1'b1;
            lane_data[k*8 +: 8] = gen(idx, k);
          end
        end
        tick++;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; lane_vld = '0; lane_data = '0;
    // spread 3, common pauses
    run(0, 1, 2, 3, 80, 1'b1, -1, 0);
    chk(got_first && first_word == {4{MARK}}, "R3 first word all markers", first_word, {4{MARK}});
    chk(n_bond > 0 && n_fall == 0, "R10 bond held across markers", n_fall, 0);
    // spread exactly SKEW
    run(4, 0, 2, 1, 64, 1'b0, -1, 0);
    chk(n_bond > 0 && n_err == 0, "R4 skew at window edge bonds", n_err, 0);
    // spread beyond SKEW
    run(0, 5, 0, 0, 64, 1'b0, -1, 0);
    chk(n_err > 0 && n_bond == 0, "R5 window expiry flags error", n_bond, 0);
    // lane slip after bonding, then rebond
    run(1, 0, 0, 2, 100, 1'b0, 2, 40);
    chk(n_fall == 1 && bonded == 1, "R8 drop then rebond", {n_fall[30:0], bonded}, 32'd3);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule